// File: doc/BRIEF.md
# Load Value Predictor with Confidence Classifier

This block guesses, at fetch time, the data a load instruction will return, before the data cache is accessed. It also decides whether that guess is worth using. The guessed data is kept apart from the decision to use it. A value table holds the most recent result of each load slot. A classification table holds one saturating confidence counter per slot and decides whether the guess is used. A small fully associative constant unit lists the loads that have proven constant. Those loads may take the guessed data with no cache access and no later check.

The pipeline sends a lookup with the load's instruction address and gets back, one cycle later, the guessed value, a "use it" flag and a "constant" flag. When the load's real data is known, the pipeline sends it back on the update port together with the load's data address. The block grades the guess, moves the counter, stores the real data and, for loads already at full confidence, enrolls the load in the constant unit. Every store address is also sent to the block. A store to an enrolled data address removes that load's constant standing.

Top module: `lvp_top`

## Requirements
- R1: After reset every counter is zero, every value slot holds zero and the constant unit is empty, so a lookup returns value 0 with both flags low.
- R2: Both tables are direct mapped and untagged, indexed by instruction address bits [IDX_W+1:2]. A lookup returns the last data written by an update to that index, including an update from a different instruction address that shares the index.
- R3: An update whose real data equals the stored value raises that index's counter by one. An update whose data differs lowers it by one. The counter saturates at zero and at its all-ones maximum.
- R4: With the default 2-bit counter, values 0 and 1 give predict low, and values 2 and 3 give predict high. Only value 3 counts as the constant level.
- R5: With parameter CNT_W = 1, a counter of 0 gives predict low. A counter of 1 gives predict high and is the constant level.
- R6: An update that is correct while the counter is already at its maximum enrolls the pair (index, data address) in the constant unit. The constant flag is high only when the counter is at its maximum and the index is enrolled. When the constant flag is high, the predict flag is also high.
- R7: A store whose address equals an enrolled data address removes that entry, so the constant flag drops while predict stays as the counter gives it. A store to any other address changes nothing.
- R8: If an enrolment and a store to the same data address occur in the same cycle, the store wins and no entry is made. The counter still moves as R3 states.
- R9: Lookup results are registered: pv_valid is high exactly one cycle after lk_valid.
- R10: A lookup and an update in the same cycle see the table state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Fetch-stage lookup request |
| lk_pc | input | PC_W | Instruction address of the load being looked up |
| pv_valid | output | 1 | Lookup result valid (one cycle after request) |
| pv_value | output | DATA_W | Guessed load data |
| pv_predict | output | 1 | Use the guessed data |
| pv_const | output | 1 | Load is constant: skip the cache and the check |
| up_valid | input | 1 | Real data of a completed load is presented |
| up_pc | input | PC_W | Instruction address of the completed load |
| up_addr | input | ADDR_W | Data address the completed load read |
| up_value | input | DATA_W | Real data the load returned |
| st_valid | input | 1 | A store address is being snooped |
| st_addr | input | ADDR_W | Data address written by the store |

## Verification
The store snoop and the constant-unit enrolment can land in the same cycle, and both touch the same entry. To provoke the conflict, the bench trains a load to full confidence. It then issues the correct update that would enrol the load in the same cycle as a store to the load's data address. A following lookup must show predict high and constant low. One more correct update, with no store, must then raise the constant flag. That shows the counter stayed at its maximum while the enrolment was dropped.

// File: rtl/lvp_pkg.sv
// Shared helpers for the load value predictor.
// Assumes instruction addresses are word aligned, so the two lowest bits carry no index information.
package lvp_pkg;

    // Lowest instruction address bit used to form a table index.
    localparam int LVP_PC_LSB = 2;

    // Saturating one-step move of a confidence counter (zero-extended to 8 bits).
    function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                            input logic [7:0] cmax,
                                            input logic       up);
        if (up)
            return (cur == cmax) ? cur : cur + 8'd1;
        else
            return (cur == 8'd0) ? cur : cur - 8'd1;
    endfunction

endpackage

// File: rtl/lvp_value_table.sv
// Untagged, direct-mapped table with the last data seen per load slot.
// Two asynchronous read ports: one for the fetch lookup and one for grading an update.
// Assumes at most one write per cycle. A read in the same cycle as a write returns the old value.
module lvp_value_table #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_val,
    input  logic [IDX_W-1:0]  cmp_idx,
    output logic [DATA_W-1:0] cmp_val,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] slot_q [DEPTH];

    assign rd_val  = slot_q[rd_idx];
    assign cmp_val = slot_q[cmp_idx];

    // Clear on reset; overwrite one slot with the real data on update.
    always_ff @(posedge clk) begin : p_slot_write
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_val;
        end
    end

    // Checker state: remember the last write for the assertion below.
    logic              chk_w_q;
    logic [IDX_W-1:0]  chk_idx_q;
    logic [DATA_W-1:0] chk_val_q;
    always_ff @(posedge clk) begin : p_chk_capture
        if (!rst_n) begin
            chk_w_q   <= 1'b0;
            chk_idx_q <= '0;
            chk_val_q <= '0;
        end else begin
            chk_w_q   <= wr_en;
            chk_idx_q <= wr_idx;
            chk_val_q <= wr_val;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_w_q |-> (slot_q[chk_idx_q] == chk_val_q)); // R2

endmodule

// File: rtl/lvp_class_table.sv
// Untagged, direct-mapped table of saturating confidence counters.
// CNT_W = 1 or 2: the top counter bit means "predict" and all-ones means the constant level.
// Assumes at most one update per cycle. Reads return the state from before a same-cycle update.
module lvp_class_table
    import lvp_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_predict,
    output logic             rd_const,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_correct,
    output logic             up_at_max
);
    localparam int             DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cnt_q [DEPTH];
    logic [CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0] up_cnt;
    logic [CNT_W-1:0] nxt_cnt;
    logic [7:0]       nxt_wide;

    assign rd_cnt    = cnt_q[rd_idx];
    assign up_cnt    = cnt_q[up_idx];
    assign up_at_max = (up_cnt == CMAX);

    generate
        if (CNT_W == 1) begin : g_single
            assign rd_predict = rd_cnt[0];
            assign rd_const   = rd_cnt[0];
        end else begin : g_multi
            assign rd_predict = rd_cnt[CNT_W-1];
            assign rd_const   = (rd_cnt == CMAX);
        end
    endgenerate

    // Next counter value for the slot being graded.
    always_comb begin : p_next_cnt
        nxt_wide = sat_step(8'(up_cnt), 8'(CMAX), up_correct);
        nxt_cnt  = nxt_wide[CNT_W-1:0];
    end

    // Clear on reset; store the stepped counter on update.
    always_ff @(posedge clk) begin : p_cnt_write
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
        end else if (up_en) begin
            cnt_q[up_idx] <= nxt_cnt;
        end
    end

    // Checker state: the slot written and its value before the write.
    logic             chk_w_q;
    logic [IDX_W-1:0] chk_idx_q;
    logic [CNT_W:0]   chk_old_q;
    logic [CNT_W:0]   chk_new;
    always_ff @(posedge clk) begin : p_chk_capture
        if (!rst_n) begin
            chk_w_q   <= 1'b0;
            chk_idx_q <= '0;
            chk_old_q <= '0;
        end else begin
            chk_w_q   <= up_en;
            chk_idx_q <= up_idx;
            chk_old_q <= {1'b0, up_cnt};
        end
    end
    assign chk_new = {1'b0, cnt_q[chk_idx_q]};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        chk_w_q |-> ((chk_new == chk_old_q + 1'b1) ||
                     (chk_new + 1'b1 == chk_old_q) ||
                     ((chk_new == chk_old_q) &&
                      (chk_old_q == '0 || chk_old_q == {1'b0, CMAX})))); // R3

endmodule

// File: rtl/lvp_const_unit.sv
// Small fully associative list of (load index, data address) pairs for constant loads.
// A lookup hits on the load index. A snooped store clears every entry whose address matches.
// An insertion reuses the entry with the same index, else a free entry, else a round-robin victim.
// Assumes at most one insertion and one store per cycle. A store matching the insertion address blocks it.
module lvp_const_unit #(
    parameter int IDX_W   = 6,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_hit,
    input  logic              ins_en,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_en,
    input  logic [ADDR_W-1:0] st_addr
);
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic              vld_q  [ENTRIES];
    logic [IDX_W-1:0]  idx_q  [ENTRIES];
    logic [ADDR_W-1:0] addr_q [ENTRIES];
    logic [SLOT_W-1:0] rr_q;

    logic [ENTRIES-1:0] lk_match, ins_match, free_vec, st_match;
    logic [SLOT_W-1:0]  sel;
    logic               use_rr;
    logic               ins_ok;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign lk_match[i]  = vld_q[i] && (idx_q[i] == lk_idx);
            assign ins_match[i] = vld_q[i] && (idx_q[i] == ins_idx);
            assign free_vec[i]  = !vld_q[i];
            assign st_match[i]  = vld_q[i] && (addr_q[i] == st_addr);
        end
    endgenerate

    assign lk_hit = |lk_match;
    assign ins_ok = ins_en && !(st_en && (st_addr == ins_addr));

    // Pick the entry an insertion writes: same index, lowest free, or round-robin victim.
    always_comb begin : p_victim
        sel    = '0;
        use_rr = 1'b0;
        if (|ins_match) begin
            for (int i = 0; i < ENTRIES; i++)
                if (ins_match[i]) sel = SLOT_W'(i);
        end else if (|free_vec) begin
            for (int i = ENTRIES - 1; i >= 0; i--)
                if (free_vec[i]) sel = SLOT_W'(i);
        end else begin
            sel    = rr_q;
            use_rr = 1'b1;
        end
    end

    // Apply store invalidations first, then the (possibly blocked) insertion.
    always_ff @(posedge clk) begin : p_entries
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i]  <= 1'b0;
                idx_q[i]  <= '0;
                addr_q[i] <= '0;
            end
            rr_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++)
                if (st_en && st_match[i]) vld_q[i] <= 1'b0;
            if (ins_ok) begin
                vld_q[sel]  <= 1'b1;
                idx_q[sel]  <= ins_idx;
                addr_q[sel] <= ins_addr;
                if (use_rr)
                    rr_q <= (rr_q == SLOT_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // Checker state: the last snooped store, and whether any valid entry still holds its address.
    logic              chk_st_q;
    logic [ADDR_W-1:0] chk_addr_q;
    logic              chk_stale;
    always_ff @(posedge clk) begin : p_chk_capture
        if (!rst_n) begin
            chk_st_q   <= 1'b0;
            chk_addr_q <= '0;
        end else begin
            chk_st_q   <= st_en;
            chk_addr_q <= st_addr;
        end
    end
    always_comb begin : p_chk_stale
        chk_stale = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (vld_q[i] && (addr_q[i] == chk_addr_q)) chk_stale = 1'b1;
    end

    AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_st_q |-> !chk_stale); // R7
    AST_SNOOP_BEATS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && ins_en && (st_addr == ins_addr)) |=> !chk_stale); // R8

endmodule

// File: rtl/lvp_top.sv
// Load value predictor top: value table, confidence table and constant unit.
// Lookups are registered (one cycle). Updates grade the stored value, step the counter,
// overwrite the value and enrol loads that are correct at full confidence.
// Assumes the caller presents at most one lookup, one update and one store snoop per cycle.
module lvp_top
    import lvp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int IDX_W       = 6,
    parameter int CNT_W       = 2,
    parameter int CVU_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              pv_valid,
    output logic [DATA_W-1:0] pv_value,
    output logic              pv_predict,
    output logic              pv_const,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_value,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr
);
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [DATA_W-1:0] lk_val, up_old;
    logic              lk_pred, lk_cls_const, lk_hit;
    logic              up_correct, up_at_max, ins_en;

    assign lk_idx     = lk_pc[LVP_PC_LSB +: IDX_W];
    assign up_idx     = up_pc[LVP_PC_LSB +: IDX_W];
    assign up_correct = (up_old == up_value);
    assign ins_en     = up_valid && up_correct && up_at_max;

    lvp_value_table #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_vtab (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_idx),
        .rd_val  (lk_val),
        .cmp_idx (up_idx),
        .cmp_val (up_old),
        .wr_en   (up_valid),
        .wr_idx  (up_idx),
        .wr_val  (up_value)
    );

    lvp_class_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctab (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (lk_idx),
        .rd_predict (lk_pred),
        .rd_const   (lk_cls_const),
        .up_en      (up_valid),
        .up_idx     (up_idx),
        .up_correct (up_correct),
        .up_at_max  (up_at_max)
    );

    lvp_const_unit #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .ENTRIES(CVU_ENTRIES)) u_cvu (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_hit   (lk_hit),
        .ins_en   (ins_en),
        .ins_idx  (up_idx),
        .ins_addr (up_addr),
        .st_en    (st_valid),
        .st_addr  (st_addr)
    );

    // Register the lookup result for the fetch stage.
    always_ff @(posedge clk) begin : p_lookup_out
        if (!rst_n) begin
            pv_valid   <= 1'b0;
            pv_value   <= '0;
            pv_predict <= 1'b0;
            pv_const   <= 1'b0;
        end else begin
            pv_valid   <= lk_valid;
            pv_value   <= lk_val;
            pv_predict <= lk_pred;
            pv_const   <= lk_cls_const && lk_hit;
        end
    end

    AST_PV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pv_valid == $past(lk_valid))); // R9
    AST_CONST_NEEDS_PREDICT: assert property (@(posedge clk) disable iff (!rst_n)
        pv_const |-> pv_predict); // R6

endmodule

// File: tb/lvp_top_tb_top.sv
`timescale 1ns/1ps
module lvp_top_tb_top;

    typedef struct {
        logic [31:0] value;
        logic        pred;
        logic        konst;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_addr = '0;
    logic [31:0] up_value = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;

    logic        pv_valid, pv_predict, pv_const;
    logic [31:0] pv_value;
    logic        p1_valid, p1_predict, p1_const;
    logic [31:0] p1_value;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    lvp_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .pv_valid(pv_valid), .pv_value(pv_value), .pv_predict(pv_predict), .pv_const(pv_const),
        .up_valid(up_valid), .up_pc(up_pc), .up_addr(up_addr), .up_value(up_value),
        .st_valid(st_valid), .st_addr(st_addr)
    );

    // Same stimulus, 1-bit counter variant (R5).
    lvp_top #(.CNT_W(1)) dut1_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .pv_valid(p1_valid), .pv_value(p1_value), .pv_predict(p1_predict), .pv_const(p1_const),
        .up_valid(up_valid), .up_pc(up_pc), .up_addr(up_addr), .up_value(up_value),
        .st_valid(st_valid), .st_addr(st_addr)
    );

    task automatic begin_cyc();
        @(negedge clk);
    endtask

    task automatic end_cyc();
        @(negedge clk);
        lk_valid = 1'b0;
        up_valid = 1'b0;
        st_valid = 1'b0;
    endtask

    task automatic set_lookup(input logic [31:0] pc, input logic [31:0] v,
                              input logic p, input logic c, input string tag);
        exp_t e;
        e.value = v; e.pred = p; e.konst = c; e.tag = tag;
        exp_q.push_back(e);
        lk_valid = 1'b1;
        lk_pc    = pc;
    endtask

    task automatic set_update(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] v);
        up_valid = 1'b1; up_pc = pc; up_addr = a; up_value = v;
    endtask

    task automatic set_store(input logic [31:0] a);
        st_valid = 1'b1; st_addr = a;
    endtask

    task automatic lookup(input logic [31:0] pc, input logic [31:0] v,
                          input logic p, input logic c, input string tag);
        begin_cyc(); set_lookup(pc, v, p, c, tag); end_cyc();
    endtask

    task automatic update(input logic [31:0] pc, input logic [31:0] a, input logic [31:0] v);
        begin_cyc(); set_update(pc, a, v); end_cyc();
    endtask

    task automatic store(input logic [31:0] a);
        begin_cyc(); set_store(a); end_cyc();
    endtask

    // Direct check of the 1-bit instance right after a lookup cycle.
    task automatic check1(input logic [31:0] v, input logic p, input logic c, input string tag);
        n_checks++;
        if (!(p1_valid && p1_value == v && p1_predict == p && p1_const == c)) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b value=%h pred=%0b const=%0b, expected valid=1 value=%h pred=%0b const=%0b",
                     tag, p1_valid, p1_value, p1_predict, p1_const, v, p, c);
        end
    endtask

    // Monitor: mid-cycle, compare every lookup result with the scoreboard head.
    initial begin : p_monitor
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && pv_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: result with no request, got value=%h expected none", pv_value);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (pv_value !== e.value || pv_predict !== e.pred || pv_const !== e.konst) begin
                        n_fail++;
                        $display("FAIL %s: got value=%h pred=%0b const=%0b, expected value=%h pred=%0b const=%0b",
                                 e.tag, pv_value, pv_predict, pv_const, e.value, e.pred, e.konst);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin : p_watchdog
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : p_main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R9: idle output after reset
        n_checks++;
        if (pv_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: got pv_valid=%0b, expected 0", pv_valid);
        end
        lookup(32'h100, 32'h0, 1'b0, 1'b0, "R1 reset state");

        // Phase A: train, alias, snoop, decrement, saturate at zero
        update(32'h40, 32'h1000, 32'd5);
        lookup(32'h40, 32'd5, 1'b0, 1'b0, "R2 last value, R3 wrong keeps 0");
        update(32'h40, 32'h1000, 32'd5);
        lookup(32'h40, 32'd5, 1'b0, 1'b0, "R4 counter 1 no predict");
        update(32'h40, 32'h1000, 32'd5);
        lookup(32'h40, 32'd5, 1'b1, 1'b0, "R4 counter 2 predict");
        update(32'h40, 32'h1000, 32'd5);
        lookup(32'h40, 32'd5, 1'b1, 1'b0, "R6 counter 3 not enrolled");
        update(32'h40, 32'h1000, 32'd5);
        lookup(32'h40, 32'd5, 1'b1, 1'b1, "R6 enrolled constant");
        lookup(32'h140, 32'd5, 1'b1, 1'b1, "R2 alias shares slot");
        store(32'h2000);
        lookup(32'h40, 32'd5, 1'b1, 1'b1, "R7 unrelated store");
        store(32'h1000);
        lookup(32'h40, 32'd5, 1'b1, 1'b0, "R7 matching store clears");
        update(32'h40, 32'h1000, 32'd7);
        lookup(32'h40, 32'd7, 1'b1, 1'b0, "R3 decrement to 2");
        update(32'h40, 32'h1000, 32'd9);
        lookup(32'h40, 32'd9, 1'b0, 1'b0, "R3 decrement to 1");
        update(32'h40, 32'h1000, 32'd8);
        update(32'h40, 32'h1000, 32'd6);
        lookup(32'h40, 32'd6, 1'b0, 1'b0, "R3 floor at 0");
        update(32'h40, 32'h1000, 32'd6);
        lookup(32'h40, 32'd6, 1'b0, 1'b0, "R3 up from floor to 1");
        update(32'h40, 32'h1000, 32'd6);
        lookup(32'h40, 32'd6, 1'b1, 1'b0, "R3 no wrap below 0");

        // Phase B: enrolment and snoop in the same cycle
        update(32'h80, 32'h3000, 32'd11);
        for (int k = 0; k < 3; k++) update(32'h80, 32'h3000, 32'd11);
        begin_cyc(); set_update(32'h80, 32'h3000, 32'd11); set_store(32'h3000); end_cyc();
        lookup(32'h80, 32'd11, 1'b1, 1'b0, "R8 store beats enrolment");
        update(32'h80, 32'h3000, 32'd11);
        lookup(32'h80, 32'd11, 1'b1, 1'b1, "R8 counter kept at max, R3 ceiling");

        // Phase C: lookup and update together
        begin_cyc();
        set_update(32'hC0, 32'h5000, 32'h55);
        set_lookup(32'hC0, 32'h0, 1'b0, 1'b0, "R10 lookup sees old state");
        end_cyc();
        lookup(32'hC0, 32'h55, 1'b0, 1'b0, "R10 update visible next");

        // Phase D: 1-bit counter variant
        update(32'h10, 32'h4000, 32'd3);
        lookup(32'h10, 32'd3, 1'b0, 1'b0, "R5 2-bit ref cnt0");
        check1(32'd3, 1'b0, 1'b0, "R5 1-bit cnt0");
        update(32'h10, 32'h4000, 32'd3);
        lookup(32'h10, 32'd3, 1'b0, 1'b0, "R5 2-bit ref cnt1");
        check1(32'd3, 1'b1, 1'b0, "R5 1-bit cnt1 predict");
        update(32'h10, 32'h4000, 32'd3);
        lookup(32'h10, 32'd3, 1'b1, 1'b0, "R5 2-bit ref cnt2");
        check1(32'd3, 1'b1, 1'b1, "R5 1-bit constant");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: got %0d results missing, expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule